// File: doc/BRIEF.md
# Instruction Fetch and Length Sequencer

This block fetches one instruction of an 8-bit processor from a byte-wide read port. A pulse on `start` captures a program counter and a taken-branch hint. The block then reads the opcode byte at that address and decodes its addressing mode from a small built-in lookup in the same cycle the byte arrives. That mode decides whether zero, one or two operand bytes follow, and the block reads them at successive addresses.

When the fetch completes, `done` pulses for one cycle. The captured opcode, operands, mode, instruction length and the address of the following instruction are then presented and held until the next fetch begins. The following address is the current one plus the length. For a relative-mode instruction whose branch hint was set, it is the current address plus the sign-extended first operand plus two. All address arithmetic wraps at the width of the program counter.

The read port has one cycle of latency per byte. A low `mem_valid` stalls the sequencer on the current byte. Opcodes that the lookup does not know are handled as one-byte instructions with no operands and are flagged.

Top module: `insn_fetch_seq`

## Requirements
- R1: After reset, `done`, `mem_rd`, `illegal`, `opcode`, `op1` and `op2` are all zero.
- R2: A `start` seen while idle causes, in the next cycle, `mem_rd`=1 with `mem_addr` equal to the `pc_in` value presented with `start`. A `start` seen while a fetch is in progress or while `done` is high has no effect on the address sequence or the results.
- R3: `mode` is coded as follows: 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page+X, 5 zero page+Y, 6 zero-page indirect, 7 indexed indirect by X, 8 indirect indexed by Y, 9 relative, 10 absolute, 11 absolute+X, 12 absolute+Y, 13 absolute indirect, 14 absolute indexed indirect, 15 zero page with relative. The lookup maps the following opcodes: EA, E8 and 00 to 0; 0A to 1; A9 to 2; A5 to 3; B5 to 4; B6 to 5; B2 to 6; A1 to 7; B1 to 8; D0 and F0 to 9; AD to 10; BD to 11; B9 to 12; 6C to 13; 7C to 14; 0F to 15 (all values hexadecimal).
- R4: Modes 0 and 1 read only the opcode. Modes 2 to 9 also read one byte at PC+1. Modes 10 to 15 also read PC+1 and then PC+2. `size` equals 1 plus the number of operand bytes read.
- R5: `op1` is the byte read from PC+1, which is the low address byte. `op2` is the byte read from PC+2, which is the high address byte. An operand that was not read shows as zero.
- R6: Unless R7 applies, `next_pc` = (PC + `size`) mod 2^16.
- R7: For mode 9 with `branch_taken` high at `start`, `next_pc` = (PC + sign-extended `op1` + 2) mod 2^16. For every other mode, `branch_taken` has no effect.
- R8: An opcode that R3 does not list yields mode 0, size 1 and `illegal`=1. A listed opcode yields `illegal`=0.
- R9: While `mem_rd` is high and `mem_valid` is low, `mem_addr` holds, the bus data is ignored, and the sequencer waits on that byte.
- R10: With no stalls, `done` goes high (1 + `size`) cycles after the cycle in which `start` is accepted. It stays high for exactly one cycle. The block then spends one idle cycle with `mem_rd` low before it can accept a new start. The results hold after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch (accepted only while idle) |
| pc_in | input | 16 | Address of the instruction to fetch |
| branch_taken | input | 1 | Branch hint, captured with `start` |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read request |
| mem_data | input | 8 | Read data |
| mem_valid | input | 1 | Read data valid for the current request |
| done | output | 1 | One-cycle completion pulse |
| opcode | output | 8 | Fetched opcode byte |
| op1 | output | 8 | First operand byte (low) |
| op2 | output | 8 | Second operand byte (high) |
| mode | output | 4 | Addressing mode code |
| size | output | 2 | Instruction length in bytes |
| next_pc | output | 16 | Address of the following instruction |
| illegal | output | 1 | Opcode not in the lookup |

## Verification
The opcode byte is decoded in the same cycle it is captured, and that decode chooses the next state. A stall falling in that same cycle is the case that matters. The bench therefore repeats the mode table with `mem_valid` high only one cycle in four, and it drives a junk value on `mem_data` whenever `mem_valid` is low. Each completed read is compared against the expected address sequence, and the captured fields and operand count must match the unstalled run exactly. A second overlap, a new `start` arriving during the `done` cycle, is provoked by holding `start` high. It is judged by seeing one idle cycle and then a fresh opcode read at `pc_in`.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [3:0] {
    M_IMP   = 4'd0,
    M_ACC   = 4'd1,
    M_IMM   = 4'd2,
    M_ZP    = 4'd3,
    M_ZPX   = 4'd4,
    M_ZPY   = 4'd5,
    M_IZP   = 4'd6,
    M_IZPX  = 4'd7,
    M_IZPY  = 4'd8,
    M_REL   = 4'd9,
    M_ABS   = 4'd10,
    M_ABSX  = 4'd11,
    M_ABSY  = 4'd12,
    M_IABS  = 4'd13,
    M_IABSX = 4'd14,
    M_ZPR   = 4'd15
  } amode_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_OPCODE = 3'd1,
    S_OP1    = 3'd2,
    S_OP2    = 3'd3,
    S_DONE   = 3'd4
  } fstate_e;

  // operand bytes that follow the opcode for a given mode
  function automatic logic [1:0] operand_bytes(amode_e m);
    if (m == M_IMP || m == M_ACC) return 2'd0;
    else if (m >= M_ABS)          return 2'd2;
    else                          return 2'd1;
  endfunction

  function automatic logic [1:0] insn_len(amode_e m);
    return operand_bytes(m) + 2'd1;
  endfunction

endpackage

// File: rtl/fetch_mode_lut.sv
module fetch_mode_lut
  import fetch_pkg::*;
(
  input  logic [7:0] opc,
  output amode_e     mode,
  output logic       known
);

  always_comb begin
    known = 1'b1;
    case (opc)
      8'hEA, 8'hE8, 8'h00: mode = M_IMP;
      8'h0A:               mode = M_ACC;
      8'hA9:               mode = M_IMM;
      8'hA5:               mode = M_ZP;
      8'hB5:               mode = M_ZPX;
      8'hB6:               mode = M_ZPY;
      8'hB2:               mode = M_IZP;
      8'hA1:               mode = M_IZPX;
      8'hB1:               mode = M_IZPY;
      8'hD0, 8'hF0:        mode = M_REL;
      8'hAD:               mode = M_ABS;
      8'hBD:               mode = M_ABSX;
      8'hB9:               mode = M_ABSY;
      8'h6C:               mode = M_IABS;
      8'h7C:               mode = M_IABSX;
      8'h0F:               mode = M_ZPR;
      default: begin
        mode  = M_IMP;
        known = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mem_valid,
  input  logic [1:0] nops_new,
  input  logic [1:0] nops_held,
  output logic       accept,
  output logic       mem_rd,
  output logic       cap_opc,
  output logic       cap_op1,
  output logic       cap_op2,
  output logic       done,
  output logic [1:0] byte_idx
);

  fstate_e st, st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    accept   = (st == S_IDLE) && start;
    mem_rd   = (st == S_OPCODE) || (st == S_OP1) || (st == S_OP2);
    cap_opc  = (st == S_OPCODE) && mem_valid;
    cap_op1  = (st == S_OP1) && mem_valid;
    cap_op2  = (st == S_OP2) && mem_valid;
    done     = (st == S_DONE);
    byte_idx = (st == S_OP1) ? 2'd1 : (st == S_OP2) ? 2'd2 : 2'd0;
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:   if (start) st_nx = S_OPCODE;
      S_OPCODE: if (mem_valid) st_nx = (nops_new == 2'd0) ? S_DONE : S_OP1;
      S_OP1:    if (mem_valid) st_nx = (nops_held == 2'd2) ? S_OP2 : S_DONE;
      S_OP2:    if (mem_valid) st_nx = S_DONE;
      S_DONE:   st_nx = S_IDLE;
      default:  st_nx = S_IDLE;
    endcase
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !mem_rd);

  assert_start_opens_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_rd && byte_idx == 2'd0);

  assert_stall_holds_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_valid) |=> mem_rd && $stable(byte_idx));

endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] pc_in,
  input  logic          br_in,
  input  logic [1:0]    byte_idx,
  input  logic [1:0]    len,
  input  logic          rel_mode,
  input  logic [7:0]    disp,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] next_pc
);

  localparam int EXT = AW - 8;

  logic [AW-1:0] pc_q;
  logic          br_q;

  function automatic logic [AW-1:0] pc_plus(input logic [AW-1:0] b, input logic [1:0] k);
    return b + AW'(k);
  endfunction

  function automatic logic [AW-1:0] branch_dest(input logic [AW-1:0] b, input logic [7:0] d);
    return b + {{EXT{d[7]}}, d} + AW'(2);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      br_q <= 1'b0;
    end else if (accept) begin
      pc_q <= pc_in;
      br_q <= br_in;
    end
  end

  assign mem_addr = pc_plus(pc_q, byte_idx);
  assign next_pc  = (rel_mode && br_q) ? branch_dest(pc_q, disp) : pc_plus(pc_q, len);

  assert_first_read_at_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_addr == $past(pc_in));

endmodule

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq
  import fetch_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] pc_in,
  input  logic          branch_taken,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [7:0]    mem_data,
  input  logic          mem_valid,
  output logic          done,
  output logic [7:0]    opcode,
  output logic [7:0]    op1,
  output logic [7:0]    op2,
  output logic [3:0]    mode,
  output logic [1:0]    size,
  output logic [AW-1:0] next_pc,
  output logic          illegal
);

  amode_e     lut_mode, mode_q;
  logic       lut_known;
  logic       accept, cap_opc, cap_op1, cap_op2;
  logic [1:0] byte_idx;
  logic [7:0] opcode_q, op1_q, op2_q;
  logic       ill_q;

  fetch_mode_lut u_lut (
    .opc   (mem_data),
    .mode  (lut_mode),
    .known (lut_known)
  );

  fetch_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_valid (mem_valid),
    .nops_new  (operand_bytes(lut_mode)),
    .nops_held (operand_bytes(mode_q)),
    .accept    (accept),
    .mem_rd    (mem_rd),
    .cap_opc   (cap_opc),
    .cap_op1   (cap_op1),
    .cap_op2   (cap_op2),
    .done      (done),
    .byte_idx  (byte_idx)
  );

  fetch_pc_unit #(.AW(AW)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .pc_in    (pc_in),
    .br_in    (branch_taken),
    .byte_idx (byte_idx),
    .len      (insn_len(mode_q)),
    .rel_mode (mode_q == M_REL),
    .disp     (op1_q),
    .mem_addr (mem_addr),
    .next_pc  (next_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0;
      op1_q    <= '0;
      op2_q    <= '0;
      mode_q   <= M_IMP;
      ill_q    <= 1'b0;
    end else begin
      if (accept) begin
        op1_q <= '0;
        op2_q <= '0;
      end
      if (cap_opc) begin
        opcode_q <= mem_data;
        mode_q   <= lut_mode;
        ill_q    <= !lut_known;
      end
      if (cap_op1) op1_q <= mem_data;
      if (cap_op2) op2_q <= mem_data;
    end
  end

  assign opcode  = opcode_q;
  assign op1     = op1_q;
  assign op2     = op2_q;
  assign mode    = mode_q;
  assign size    = insn_len(mode_q);
  assign illegal = ill_q;

  // count of bytes taken from the bus since the fetch began
  logic [1:0] rd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            rd_cnt <= '0;
    else if (accept)                       rd_cnt <= '0;
    else if (cap_opc || cap_op1 || cap_op2) rd_cnt <= rd_cnt + 2'd1;
  end

  assert_reads_match_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rd_cnt == size);

  assert_stall_holds_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_valid) |=> mem_rd && $stable(mem_addr));

  assert_illegal_is_implied_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> mode == 4'd0 && size == 2'd1);

  assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(opcode) && $stable(op1) && $stable(op2) && $stable(next_pc));

endmodule

// File: tb/tb_insn_fetch_seq.sv
module tb_insn_fetch_seq;

  localparam int CLK_NS = 10;
  localparam int NV     = 23;

  typedef struct packed {
    logic [15:0] pc;
    logic        br;
    logic [7:0]  opc;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [3:0]  md;
    logic [1:0]  sz;
    logic        ill;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'h1000, 1'b0, 8'hEA, 8'h11, 8'h22, 4'd0,  2'd1, 1'b0},
    '{16'h1010, 1'b0, 8'h0A, 8'h11, 8'h22, 4'd1,  2'd1, 1'b0},
    '{16'h2000, 1'b0, 8'hA9, 8'h42, 8'h22, 4'd2,  2'd2, 1'b0},
    '{16'h2010, 1'b0, 8'hA5, 8'h10, 8'h22, 4'd3,  2'd2, 1'b0},
    '{16'h2020, 1'b0, 8'hB5, 8'h80, 8'h22, 4'd4,  2'd2, 1'b0},
    '{16'h2030, 1'b0, 8'hB6, 8'hFF, 8'h22, 4'd5,  2'd2, 1'b0},
    '{16'h2040, 1'b0, 8'hB2, 8'h12, 8'h22, 4'd6,  2'd2, 1'b0},
    '{16'h2050, 1'b0, 8'hA1, 8'h34, 8'h22, 4'd7,  2'd2, 1'b0},
    '{16'h2060, 1'b0, 8'hB1, 8'h56, 8'h22, 4'd8,  2'd2, 1'b0},
    '{16'h2070, 1'b0, 8'hD0, 8'h10, 8'h22, 4'd9,  2'd2, 1'b0},
    '{16'h2070, 1'b1, 8'hD0, 8'h10, 8'h22, 4'd9,  2'd2, 1'b0},
    '{16'h3000, 1'b1, 8'hF0, 8'hF0, 8'h22, 4'd9,  2'd2, 1'b0},
    '{16'h4000, 1'b0, 8'hAD, 8'h34, 8'h12, 4'd10, 2'd3, 1'b0},
    '{16'h4010, 1'b0, 8'hBD, 8'h78, 8'h56, 4'd11, 2'd3, 1'b0},
    '{16'h4020, 1'b0, 8'hB9, 8'hBC, 8'h9A, 4'd12, 2'd3, 1'b0},
    '{16'h4030, 1'b0, 8'h6C, 8'h00, 8'h80, 4'd13, 2'd3, 1'b0},
    '{16'h4040, 1'b0, 8'h7C, 8'hFE, 8'hFF, 4'd14, 2'd3, 1'b0},
    '{16'h4050, 1'b1, 8'h0F, 8'h20, 8'h05, 4'd15, 2'd3, 1'b0},
    '{16'h5000, 1'b0, 8'h02, 8'h99, 8'h88, 4'd0,  2'd1, 1'b1},
    '{16'h5010, 1'b1, 8'hE8, 8'h99, 8'h88, 4'd0,  2'd1, 1'b0},
    '{16'hFFFE, 1'b0, 8'hAD, 8'h34, 8'h12, 4'd10, 2'd3, 1'b0},
    '{16'hFFF0, 1'b1, 8'hD0, 8'h7F, 8'h22, 4'd9,  2'd2, 1'b0},
    '{16'h0100, 1'b1, 8'hB2, 8'h90, 8'h22, 4'd6,  2'd2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pc_in = '0;
  logic        branch_taken = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_data;
  logic        mem_valid;
  logic        done;
  logic [7:0]  opcode, op1, op2;
  logic [3:0]  mode;
  logic [1:0]  size;
  logic [15:0] next_pc;
  logic        illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [15:0] m_base = '0;
  logic [7:0]  m_b0 = '0, m_b1 = '0, m_b2 = '0;
  logic        stall_en = 1'b0;
  logic [7:0]  cyc = '0;
  int          rd_seen = 0;
  logic [15:0] off;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 8'd1;

  always_comb begin
    off       = mem_addr - m_base;
    mem_valid = mem_rd && (!stall_en || cyc[1:0] == 2'b11);
    if (!mem_valid)       mem_data = 8'hC3;
    else if (off == 16'd0) mem_data = m_b0;
    else if (off == 16'd1) mem_data = m_b1;
    else if (off == 16'd2) mem_data = m_b2;
    else                   mem_data = 8'h5A;
  end

  insn_fetch_seq dut (
    .clk (clk), .rst_n (rst_n), .start (start), .pc_in (pc_in),
    .branch_taken (branch_taken), .mem_addr (mem_addr), .mem_rd (mem_rd),
    .mem_data (mem_data), .mem_valid (mem_valid), .done (done),
    .opcode (opcode), .op1 (op1), .op2 (op2), .mode (mode), .size (size),
    .next_pc (next_pc), .illegal (illegal)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // every completed read must land on the next expected address (R4, R9)
  always @(negedge clk) begin
    if (rd_n && mem_rd && mem_valid) begin
      chk(mem_addr == 16'(m_base + rd_seen), "R4", "read address", mem_addr, 16'(m_base + rd_seen));
      rd_seen++;
    end
  end
  logic rd_n;
  assign rd_n = rst_n;

  function automatic logic [15:0] exp_next(input logic [15:0] pc, input int sz, input int md,
                                           input bit br, input logic [7:0] d);
    int t;
    int sd;
    sd = (d >= 8'd128) ? int'(d) - 256 : int'(d);
    if (md == 9 && br) t = int'(pc) + sd + 2;
    else               t = int'(pc) + sz;
    return 16'(t & 32'hFFFF);
  endfunction

  task automatic load_mem(input vec_t v);
    m_base = v.pc; m_b0 = v.opc; m_b1 = v.b1; m_b2 = v.b2;
  endtask

  task automatic check_result(input vec_t v);
    logic [7:0] e1, e2;
    e1 = (v.sz >= 2'd2) ? v.b1 : 8'h00;
    e2 = (v.sz == 2'd3) ? v.b2 : 8'h00;
    chk(opcode == v.opc, "R3", "opcode", opcode, v.opc);
    chk(mode == v.md, "R3", "mode", mode, v.md);
    chk(size == v.sz, "R4", "size", size, v.sz);
    chk(rd_seen == int'(v.sz), "R4", "reads done", rd_seen, v.sz);
    chk(op1 == e1, "R5", "op1", op1, e1);
    chk(op2 == e2, "R5", "op2", op2, e2);
    chk(illegal == v.ill, "R8", "illegal", illegal, v.ill);
    chk(next_pc == exp_next(v.pc, v.sz, v.md, v.br, v.b1),
        (v.md == 4'd9) ? "R7" : "R6", "next_pc", next_pc, exp_next(v.pc, v.sz, v.md, v.br, v.b1));
  endtask

  // poke: stray start with a different PC while busy (R2)
  task automatic run_vec(input vec_t v, input bit poke, input bit check_lat);
    int cycles;
    load_mem(v);
    rd_seen = 0;
    @(negedge clk);
    pc_in = v.pc; branch_taken = v.br; start = 1'b1;
    @(negedge clk);
    start = 1'b0; branch_taken = 1'b0;
    cycles = 1;
    while (!done && cycles < 400) begin
      if (poke && cycles == 1) begin
        start = 1'b1; pc_in = 16'h9999; branch_taken = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; branch_taken = 1'b0;
      cycles++;
    end
    chk(done == 1'b1, "R10", "done reached", done, 1);
    if (check_lat) chk(cycles == 1 + int'(v.sz), "R10", "latency", cycles, 1 + v.sz);
    check_result(v);
    @(negedge clk);
    chk(done == 1'b0 && mem_rd == 1'b0, "R10", "idle after done", {done, mem_rd}, 0);
    chk(opcode == v.opc, "R10", "opcode held", opcode, v.opc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_rd == 1'b0, "R1", "done/mem_rd at reset", {done, mem_rd}, 0);
    chk(opcode == 8'h00 && op1 == 8'h00 && op2 == 8'h00, "R1", "fields at reset",
        {opcode, op1, op2}, 0);
    chk(illegal == 1'b0, "R1", "illegal at reset", illegal, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk, no stalls
    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0, 1'b1);

    // same table with a slow bus and junk data during stalls (R9)
    stall_en = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0, 1'b0);
    stall_en = 1'b0;

    // stray start mid-fetch is ignored (R2)
    run_vec(VECS[12], 1'b1, 1'b1);
    run_vec(VECS[10], 1'b1, 1'b1);

    // first read address after start (R2)
    load_mem(VECS[2]);
    rd_seen = 0;
    @(negedge clk);
    pc_in = VECS[2].pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mem_rd == 1'b1 && mem_addr == VECS[2].pc, "R2", "first read at pc_in", mem_addr, VECS[2].pc);
    while (!done) @(negedge clk);
    @(negedge clk);

    // start held through done: one idle cycle, then a fresh fetch (R10, R2)
    load_mem(VECS[13]);
    rd_seen = 0;
    @(negedge clk);
    pc_in = VECS[13].pc; start = 1'b1;
    @(negedge clk);
    while (!done) @(negedge clk);
    check_result(VECS[13]);
    rd_seen = 0;
    @(negedge clk);
    chk(mem_rd == 1'b0, "R10", "idle cycle with start held", mem_rd, 0);
    @(negedge clk);
    start = 1'b0;
    chk(mem_rd == 1'b1 && mem_addr == VECS[13].pc, "R2", "restart address", mem_addr, VECS[13].pc);
    while (!done) @(negedge clk);
    check_result(VECS[13]);
    @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", "run finished", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule